// File: doc/BRIEF.md
# Clock Source Selection Controller

The block picks the system clock source: an internal RC oscillator or an external crystal oscillator. It drives a power enable for each oscillator. An oscillator is powered only while something needs it, unless a keep-on override bit holds it on. When software asks for the crystal, the block powers it, counts a warmup period in RC clock cycles and changes the registered source select only once the warmup is done. If an earlier keep-on setting has already warmed the crystal, the change happens almost at once.

Software uses a small register port with two addresses. The oscillator register holds the two keep-on bits. The clock register holds the crystal-select bit and two read-only status flags: crystal ready, and RC mode.

Two reset classes exist. Power-on/brownout reset clears everything. The other reset class clears the keep-on bits and leaves the crystal-select bit and the running clock source alone.

Top module: `clk_src_ctrl`

## Requirements
- R1: After power-on reset, address 0 reads 0x0001 and address 1 reads 0x0002 (crystal select 0, RC mode 1, ready 0). Also `src_xtal`=0, `rc_pwr`=1 and `xtal_pwr`=0.
- R2: `xtal_pwr` is 1 while the crystal keep-on bit (address 0 bit 1) is set, or the crystal-select bit (address 1 bit 0) is set, or the crystal is the active source, and 0 otherwise.
- R3: `rc_pwr` is 1 while any of the following holds: the RC keep-on bit (address 0 bit 0) is set, the RC is the active source, crystal select is clear, `wdt_active` is 1, or `flash_busy` is 1.
- R4: The crystal-ready flag (address 1 bit 2, also on `xtal_rdy`) becomes 1 at the `warm_target`-th clock edge after `xtal_pwr` rises, and stays 1 while power is held. Dropping `xtal_pwr` clears the warmup count.
- R5: `src_xtal` rises at the first clock edge at which crystal select and ready are both 1. It never rises earlier.
- R6: Clearing crystal select while on crystal returns `src_xtal` to 0 at the next clock edge. The crystal stays powered until that edge.
- R7: The RC-mode flag (address 1 bit 1) reads as the inverse of `src_xtal`. It therefore shows RC while a crystal request waits for warmup.
- R8: A non-power-on reset (`rst_n` low with `por_n` high) returns the keep-on bits to RC on, crystal off. It leaves crystal select, the warmup count and `src_xtal` unchanged.
- R9: Only bit 0 of a write to address 1 is stored. The status bits are read-only. Bits 15:2 of address 0 and bits 15:3 of address 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC-domain clock |
| por_n | input | 1 | Power-on/brownout reset, active low |
| rst_n | input | 1 | Any other reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 oscillator, 1 clock |
| wr_data | input | 2 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| wdt_active | input | 1 | Watchdog needs the RC oscillator |
| flash_busy | input | 1 | Flash program/erase needs the RC oscillator |
| warm_target | input | CNT_W | Warmup length in clock cycles |
| xtal_pwr | output | 1 | Crystal oscillator power enable |
| rc_pwr | output | 1 | RC oscillator power enable |
| src_xtal | output | 1 | Registered source select, 1 = crystal |
| xtal_rdy | output | 1 | Crystal warmup finished |

## Verification
The assertions assume that `warm_target` is held constant while the crystal is powered, and that `wdt_active` and `flash_busy` are clean levels that change only between clock edges. The bench writes `warm_target` once, before the first power-on reset is released. It drives every input on the falling edge, so each input is settled before the next rising edge.

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [1:0]       wr_data,
  input  logic             rd_addr,
  output logic [15:0]      rd_data,
  input  logic             wdt_active,
  input  logic             flash_busy,
  input  logic [CNT_W-1:0] warm_target,
  output logic             xtal_pwr,
  output logic             rc_pwr,
  output logic             src_xtal,
  output logic             xtal_rdy
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             rc_keep, xtal_keep, xsel, src_q;
  logic [CNT_W-1:0] warm_cnt;
  logic             any_rst_n;

  assign any_rst_n = por_n & rst_n;

  // keep-on overrides: cleared by every reset class
  always_ff @(posedge clk or negedge any_rst_n)
    if (!any_rst_n) begin
      rc_keep   <= 1'b1;
      xtal_keep <= 1'b0;
    end else if (wr_en && !wr_addr) begin
      rc_keep   <= wr_data[0];
      xtal_keep <= wr_data[1];
    end

  // crystal select: power-on reset only
  always_ff @(posedge clk or negedge por_n)
    if (!por_n)
      xsel <= 1'b0;
    else if (wr_en && wr_addr)
      xsel <= wr_data[0];

  assign xtal_pwr = xtal_keep | xsel | src_q;

  // warmup counter, saturating
  always_ff @(posedge clk or negedge por_n)
    if (!por_n)
      warm_cnt <= '0;
    else if (!xtal_pwr)
      warm_cnt <= '0;
    else if (warm_cnt != CNT_MAX)
      warm_cnt <= warm_cnt + 1'b1;

  assign xtal_rdy = xtal_pwr & (warm_cnt >= warm_target);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)
      src_q <= 1'b0;
    else
      src_q <= xsel & xtal_rdy;

  assign src_xtal = src_q;
  assign rc_pwr   = rc_keep | ~src_q | ~xsel | wdt_active | flash_busy;

  assign rd_data = rd_addr ? {13'd0, xtal_rdy, ~src_q, xsel}
                           : {14'd0, xtal_keep, rc_keep};
endmodule

module clk_src_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic wdt_active,
  input logic flash_busy,
  input logic xtal_pwr,
  input logic rc_pwr,
  input logic src_xtal,
  input logic xtal_rdy
);
  // R6: crystal must stay powered while it is the source
  a_r6_src_powered: assert property (@(posedge clk) disable iff (!por_n)
    src_xtal |-> xtal_pwr);
  // R5: a swap to crystal only after ready was seen
  a_r5_swap_after_ready: assert property (@(posedge clk) disable iff (!por_n)
    $rose(src_xtal) |-> $past(xtal_rdy));
  // R3: RC powered whenever it drives the system
  a_r3_rc_when_source: assert property (@(posedge clk) disable iff (!por_n)
    !src_xtal |-> rc_pwr);
  // R3: watchdog and flash requests keep RC powered
  a_r3_rc_requests: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_active || flash_busy) |-> rc_pwr);
  // R4: no ready flag without crystal power
  a_r4_rdy_needs_pwr: assert property (@(posedge clk) disable iff (!por_n)
    xtal_rdy |-> xtal_pwr);
  // R4: ready never survives power loss
  a_r4_cold_after_drop: assert property (@(posedge clk) disable iff (!por_n)
    $fell(xtal_pwr) |=> !xtal_rdy || xtal_pwr);
endmodule

bind clk_src_ctrl clk_src_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .wdt_active(wdt_active), .flash_busy(flash_busy),
  .xtal_pwr(xtal_pwr), .rc_pwr(rc_pwr), .src_xtal(src_xtal), .xtal_rdy(xtal_rdy)
);

// File: tb/tb_clk_src_ctrl.sv
module tb_clk_src_ctrl;
  localparam int CNT_W = 16;
  localparam int WT    = 10;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [1:0] wr_data = '0;
  logic wdt_active = 1'b0, flash_busy = 1'b0;
  logic [CNT_W-1:0] warm_target = CNT_W'(WT);
  logic [15:0] rd_data;
  logic xtal_pwr, rc_pwr, src_xtal, xtal_rdy;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  clk_src_ctrl #(.CNT_W(CNT_W)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wdt_active(wdt_active), .flash_busy(flash_busy), .warm_target(warm_target),
    .xtal_pwr(xtal_pwr), .rc_pwr(rc_pwr), .src_xtal(src_xtal), .xtal_rdy(xtal_rdy)
  );

  // {rc_keep, wdt_active, flash_busy, expected rc_pwr} while on crystal
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0011, 4'b0101, 4'b0111,
    4'b1001, 4'b1011, 4'b1101, 4'b1111
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk(v == 16'h0001, "R1 osc reg", v, 16'h0001);
    rd(1'b1, v); chk(v == 16'h0002, "R1 clk reg", v, 16'h0002);
    chk({src_xtal, rc_pwr, xtal_pwr} == 3'b010, "R1 outputs",
        {src_xtal, rc_pwr, xtal_pwr}, 3'b010);

    // cold swap: deferred until warmup
    wr(1'b1, 2'b01);
    chk(xtal_pwr == 1'b1, "R2 select powers crystal", xtal_pwr, 1);
    rd(1'b1, v); chk(v == 16'h0003, "R7 rc mode while pending", v, 16'h0003);
    repeat (WT - 1) @(negedge clk);
    chk(xtal_rdy == 1'b0 && src_xtal == 1'b0, "R4 not ready early",
        {xtal_rdy, src_xtal}, 0);
    @(negedge clk);
    chk(xtal_rdy == 1'b1, "R4 ready at target", xtal_rdy, 1);
    chk(src_xtal == 1'b0, "R5 no swap before ready seen", src_xtal, 0);
    @(negedge clk);
    chk(src_xtal == 1'b1, "R5 swap after warmup", src_xtal, 1);
    rd(1'b1, v); chk(v == 16'h0005, "R7 rc mode cleared on crystal", v, 16'h0005);

    // R3 vector walk on crystal
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, {1'b0, VEC[i][3]});
      wdt_active = VEC[i][2]; flash_busy = VEC[i][1];
      #0.5;
      chk(rc_pwr == VEC[i][0], $sformatf("R3 vector %0d", i), rc_pwr, VEC[i][0]);
    end
    wdt_active = 1'b0; flash_busy = 1'b0;
    wr(1'b0, 2'b00);

    // swap back
    wr(1'b1, 2'b00);
    chk(src_xtal == 1'b1 && xtal_pwr == 1'b1, "R6 crystal held one cycle",
        {src_xtal, xtal_pwr}, 3);
    chk(rc_pwr == 1'b1, "R3 rc powered before swap back", rc_pwr, 1);
    @(negedge clk);
    chk(src_xtal == 1'b0, "R6 back to rc", src_xtal, 0);
    chk(xtal_pwr == 1'b0, "R2 crystal off when unused", xtal_pwr, 0);
    @(negedge clk);
    chk(xtal_rdy == 1'b0, "R4 count cleared", xtal_rdy, 0);

    // keep-warm preset: immediate swap
    wr(1'b0, 2'b11);
    chk(xtal_pwr == 1'b1, "R2 keep-on powers crystal", xtal_pwr, 1);
    repeat (WT + 2) @(negedge clk);
    chk(xtal_rdy == 1'b1 && src_xtal == 1'b0, "R2 warm while rc active",
        {xtal_rdy, src_xtal}, 2);
    wr(1'b1, 2'b01);
    @(negedge clk);
    chk(src_xtal == 1'b1, "R5 immediate swap when warm", src_xtal, 1);

    // non-power-on reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk(v == 16'h0001, "R8 keep bits reset", v, 16'h0001);
    rd(1'b1, v); chk(v == 16'h0005, "R8 select kept", v, 16'h0005);
    chk(src_xtal == 1'b1, "R8 source kept", src_xtal, 1);

    // read-only and reserved bits
    wr(1'b0, 2'b11);
    rd(1'b0, v); chk(v == 16'h0003, "R9 osc reserved zero", v, 16'h0003);
    wr(1'b0, 2'b01);
    wr(1'b1, 2'b10);
    @(negedge clk);
    rd(1'b1, v); chk(v == 16'h0002, "R9 only select stored", v, 16'h0002);

    // power-on reset clears select
    wr(1'b1, 2'b01);
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    rd(1'b1, v); chk(v == 16'h0002, "R1 por clears select", v, 16'h0002);
    chk(src_xtal == 1'b0, "R1 por source rc", src_xtal, 0);

    // interrupted warmup restarts
    wr(1'b1, 2'b01);
    repeat (5) @(negedge clk);
    wr(1'b1, 2'b00);
    wr(1'b1, 2'b01);
    repeat (WT - 1) @(negedge clk);
    chk(xtal_rdy == 1'b0, "R4 restart after drop", xtal_rdy, 0);
    @(negedge clk);
    chk(xtal_rdy == 1'b1, "R4 ready after full restart", xtal_rdy, 1);

    finish_run();
  end
endmodule